// File: doc/BRIEF.md
# Sparse Multi-Master Bus Crossbar

This block joins five bus masters to eight slave ports through a switch rather than one shared bus. Each master presents a request, a slave select, a write flag, an address and write data. It holds them until it sees an acknowledge or an error. Each slave port carries the same fields outward and returns an acknowledge and read data. Masters that target different slaves are connected at the same time, so up to five transfers proceed together.

A fixed and uneven permission matrix decides which master may reach which slave. A request to a slave outside that matrix is never forwarded; the master receives a one-cycle error instead. When several permitted masters want one slave, a round-robin arbiter local to that slave picks the winner. The winner keeps the slave until the slave acknowledges. Masters are numbered 1 to 5 and occupy bits 0 to 4 of every master-side vector. Slaves are numbered 1 to 8 and occupy bits 0 to 7 of every slave-side vector. A select value k addresses slave k+1.

Top module: `xbar_sparse`

## Requirements
- R1: A permitted, uncontended request from a master is forwarded to the selected slave. The slave port raises its request in the cycle after the master's request is first sampled and carries that master's write flag, address and write data. The slave's acknowledge and read data return to that master and to no other master.
- R2: Masters that select different permitted slaves are all connected in the same cycle, so up to five slave ports are active together. No master ever holds more than one slave port.
- R3: The permission matrix is as follows. Master 1 may reach every slave except slave 5. Masters 2 and 3 may reach slaves 2, 3, 4, 5, 7 and 8. Masters 4 and 5 may reach only slaves 4, 5, 7 and 8.
- R4: A request to a slave outside the matrix never appears on that slave port. The master receives a one-cycle error pulse in the cycle after its request is first sampled, and never an acknowledge and an error together.
- R5: When several permitted masters want one free slave, the grant goes to the first requester found when searching upward from that slave's round-robin pointer, wrapping from master 5 to master 1. Losing masters keep their requests and are served later without reissuing.
- R6: A grant is held, with an unchanged owner, until the slave acknowledges. In the next cycle the slave is free and its pointer moves to the master after the winner.
- R7: A slave port with no owner keeps its request, write flag, address and write data at zero.
- R8: Synchronous active-high reset clears every grant and every error and points every round-robin pointer at master 1.
- R9: An acknowledge from a slave port that has no owner reaches no master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 5 | Per-master request, held until acknowledge or error |
| m_we | input | 5 | Per-master write flag |
| m_sel | input | 15 | Per-master slave select, 3 bits each, value k selects slave k+1 |
| m_addr | input | 80 | Per-master address, 16 bits each |
| m_wdata | input | 160 | Per-master write data, 32 bits each |
| m_ack | output | 5 | Per-master transfer acknowledge |
| m_err | output | 5 | Per-master error pulse for a denied select |
| m_rdata | output | 160 | Per-master read data, valid with acknowledge |
| s_req | output | 8 | Per-slave request from the grant owner |
| s_we | output | 8 | Per-slave write flag |
| s_addr | output | 128 | Per-slave address, 16 bits each |
| s_wdata | output | 256 | Per-slave write data, 32 bits each |
| s_ack | input | 8 | Per-slave acknowledge |
| s_rdata | input | 256 | Per-slave read data |

## Verification
The block can refuse one master and grant another on the same slave in the same cycle. The bench provokes this by having master 1 (denied) and master 4 (permitted) select slave 5 on the same edge. It expects master 1's error exactly one cycle later and master 4's acknowledge one cycle after that, with slave 5 showing only master 4's address and data. The bench also launches five masters at once on five different slaves and expects all five acknowledges in one cycle. Every expected response is queued with its due cycle and its read data, and the read data is a function of slave number, address, data and write flag, so misrouting is caught.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    localparam int unsigned NUM_MST = 5;
    localparam int unsigned NUM_SLV = 8;
    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned DATA_W  = 32;

    localparam int unsigned SEL_W  = $clog2(NUM_SLV);
    localparam int unsigned MIDX_W = $clog2(NUM_MST);

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [MIDX_W-1:0]  midx_t;
    typedef logic [NUM_SLV-1:0] slv_vec_t;
    typedef logic [NUM_MST-1:0] mst_vec_t;

    // One transfer as carried from a master toward a slave port
    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    // Reach mask per master index; bit k set means slave k+1 is allowed
    function automatic slv_vec_t reach_of(input int unsigned m);
        case (m)
            0:       return slv_vec_t'(8'hEF);
            1, 2:    return slv_vec_t'(8'hDE);
            default: return slv_vec_t'(8'hD8);
        endcase
    endfunction

    function automatic logic may_reach(input int unsigned m, input sel_t s);
        slv_vec_t r;
        r = reach_of(m);
        return r[s];
    endfunction

    // First set bit of want found searching upward from ptr, with wrap
    function automatic midx_t rr_pick(input mst_vec_t want, input midx_t ptr);
        midx_t       pick;
        logic        found;
        logic [31:0] idx;
        pick  = ptr;
        found = 1'b0;
        for (int k = 0; k < int'(NUM_MST); k++) begin
            idx = (32'(ptr) + 32'(k)) % NUM_MST;
            if (!found && want[idx[MIDX_W-1:0]]) begin
                found = 1'b1;
                pick  = idx[MIDX_W-1:0];
            end
        end
        return pick;
    endfunction

    function automatic midx_t next_ptr(input midx_t m);
        return (m == midx_t'(NUM_MST - 1)) ? '0 : m + 1'b1;
    endfunction

endpackage

// File: rtl/xbar_req_gate.sv
module xbar_req_gate
    import xbar_pkg::*;
#(
    parameter int unsigned MST_ID = 0
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  sel_t     sel,
    output slv_vec_t want,
    output logic     err
);

    localparam slv_vec_t REACH = reach_of(MST_ID);

    logic allowed;
    logic err_q;

    assign allowed = REACH[sel];

    // Only permitted requests are offered to a slave arbiter
    always_comb begin
        want = '0;
        if (req && allowed) begin
            want[sel] = 1'b1;
        end
    end

    // Denied request answered one cycle later, one pulse only
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= req && !allowed && !err_q;
        end
    end

    assign err = err_q;

    AST_DENY_ERR_NEXT: assert property (@(posedge clk) disable iff (rst)
        (req && !allowed && !err_q) |=> err_q) else $error("denied request not answered"); // R4
    AST_ERR_FROM_DENY: assert property (@(posedge clk) disable iff (rst)
        err_q |-> $past(req && !allowed)) else $error("error without denied request"); // R4
    AST_DENY_NOT_OFFERED: assert property (@(posedge clk) disable iff (rst)
        !allowed |-> (want == '0)) else $error("denied select reached arbiter"); // R4

endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
    import xbar_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mst_vec_t want,
    input  logic     s_ack,
    output logic     busy,
    output midx_t    owner
);

    logic  busy_q;
    midx_t owner_q;
    midx_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            owner_q <= '0;
            ptr_q   <= '0;
        end else if (busy_q) begin
            if (s_ack) begin
                busy_q <= 1'b0;
                ptr_q  <= next_ptr(owner_q);
            end
        end else if (|want) begin
            busy_q  <= 1'b1;
            owner_q <= rr_pick(want, ptr_q);
        end
    end

    assign busy  = busy_q;
    assign owner = owner_q;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy_q && ptr_q == '0)) else $error("reset state wrong"); // R8
    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !s_ack) |=> (busy_q && $stable(owner_q))) else $error("grant dropped early"); // R6
    AST_RELEASE_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (busy_q && s_ack) |=> (!busy_q && ptr_q == next_ptr($past(owner_q)))) else $error("release wrong"); // R6
    AST_GRANT_WHEN_WANTED: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && (|want)) |=> busy_q) else $error("free slave not granted"); // R5

endmodule

// File: rtl/xbar_sparse.sv
module xbar_sparse
    import xbar_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_MST-1:0]          m_req,
    input  logic [NUM_MST-1:0]          m_we,
    input  logic [NUM_MST*SEL_W-1:0]    m_sel,
    input  logic [NUM_MST*ADDR_W-1:0]   m_addr,
    input  logic [NUM_MST*DATA_W-1:0]   m_wdata,
    output logic [NUM_MST-1:0]          m_ack,
    output logic [NUM_MST-1:0]          m_err,
    output logic [NUM_MST*DATA_W-1:0]   m_rdata,
    output logic [NUM_SLV-1:0]          s_req,
    output logic [NUM_SLV-1:0]          s_we,
    output logic [NUM_SLV*ADDR_W-1:0]   s_addr,
    output logic [NUM_SLV*DATA_W-1:0]   s_wdata,
    input  logic [NUM_SLV-1:0]          s_ack,
    input  logic [NUM_SLV*DATA_W-1:0]   s_rdata
);

    xfer_t             mx      [NUM_MST];
    slv_vec_t          want_m  [NUM_MST];
    mst_vec_t          want_s  [NUM_SLV];
    logic              busy    [NUM_SLV];
    midx_t             owner   [NUM_SLV];
    logic              ack_c   [NUM_MST];
    logic [DATA_W-1:0] rdata_c [NUM_MST];

    // Master side: unpack fields and gate against the permission matrix
    for (genvar i = 0; i < NUM_MST; i++) begin : g_mst
        assign mx[i].we    = m_we[i];
        assign mx[i].addr  = m_addr[i*ADDR_W +: ADDR_W];
        assign mx[i].wdata = m_wdata[i*DATA_W +: DATA_W];

        xbar_req_gate #(.MST_ID(i)) u_gate (
            .clk  (clk),
            .rst  (rst),
            .req  (m_req[i]),
            .sel  (m_sel[i*SEL_W +: SEL_W]),
            .want (want_m[i]),
            .err  (m_err[i])
        );

        assign m_ack[i]                    = ack_c[i];
        assign m_rdata[i*DATA_W +: DATA_W] = rdata_c[i];

        logic [NUM_SLV-1:0] owns;
        always_comb begin
            for (int j = 0; j < int'(NUM_SLV); j++) begin
                owns[j] = busy[j] && (owner[j] == midx_t'(i));
            end
        end

        AST_SINGLE_CONNECTION: assert property (@(posedge clk) disable iff (rst)
            $countones(owns) <= 1) else $error("master holds two slaves"); // R2
        AST_NO_ACK_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
            !(m_ack[i] && m_err[i])) else $error("ack and error together"); // R4
    end

    // Regroup requests by slave
    always_comb begin
        for (int j = 0; j < int'(NUM_SLV); j++) begin
            for (int i = 0; i < int'(NUM_MST); i++) begin
                want_s[j][i] = want_m[i][j];
            end
        end
    end

    // Slave side: one arbiter and one forward multiplexer per port
    for (genvar j = 0; j < NUM_SLV; j++) begin : g_slv
        xbar_rr_arb u_arb (
            .clk   (clk),
            .rst   (rst),
            .want  (want_s[j]),
            .s_ack (s_ack[j]),
            .busy  (busy[j]),
            .owner (owner[j])
        );

        xfer_t sx;
        always_comb begin
            sx = '0;
            if (busy[j]) begin
                for (int i = 0; i < int'(NUM_MST); i++) begin
                    if (owner[j] == midx_t'(i)) begin
                        sx = mx[i];
                    end
                end
            end
        end

        assign s_req[j]                    = busy[j];
        assign s_we[j]                     = sx.we;
        assign s_addr[j*ADDR_W +: ADDR_W]  = sx.addr;
        assign s_wdata[j*DATA_W +: DATA_W] = sx.wdata;

        AST_SLAVE_PERMITTED: assert property (@(posedge clk) disable iff (rst)
            s_req[j] |-> may_reach(32'(owner[j]), sel_t'(j))) else $error("owner outside matrix"); // R3
        AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
            !s_req[j] |-> (!s_we[j] && s_addr[j*ADDR_W +: ADDR_W] == '0
                           && s_wdata[j*DATA_W +: DATA_W] == '0)) else $error("idle port driven"); // R7
    end

    // Return path: acknowledge and read data go to the owner only
    always_comb begin
        for (int i = 0; i < int'(NUM_MST); i++) begin
            ack_c[i]   = 1'b0;
            rdata_c[i] = '0;
        end
        for (int j = 0; j < int'(NUM_SLV); j++) begin
            for (int i = 0; i < int'(NUM_MST); i++) begin
                if (busy[j] && s_ack[j] && owner[j] == midx_t'(i)) begin
                    ack_c[i]   = 1'b1;
                    rdata_c[i] = s_rdata[j*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: tb/tb_xbar_sparse.sv
module tb_xbar_sparse;
    import xbar_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [NUM_MST-1:0]        m_req = '0;
    logic [NUM_MST-1:0]        m_we = '0;
    logic [NUM_MST*SEL_W-1:0]  m_sel = '0;
    logic [NUM_MST*ADDR_W-1:0] m_addr = '0;
    logic [NUM_MST*DATA_W-1:0] m_wdata = '0;
    logic [NUM_MST-1:0]        m_ack;
    logic [NUM_MST-1:0]        m_err;
    logic [NUM_MST*DATA_W-1:0] m_rdata;
    logic [NUM_SLV-1:0]        s_req;
    logic [NUM_SLV-1:0]        s_we;
    logic [NUM_SLV*ADDR_W-1:0] s_addr;
    logic [NUM_SLV*DATA_W-1:0] s_wdata;
    logic [NUM_SLV-1:0]        s_ack;
    logic [NUM_SLV*DATA_W-1:0] s_rdata;

    xbar_sparse dut (
        .clk(clk), .rst(rst),
        .m_req(m_req), .m_we(m_we), .m_sel(m_sel), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_ack(s_ack), .s_rdata(s_rdata)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] resp_word(input int j, input logic we,
                                              input logic [15:0] a, input logic [31:0] d);
        return d ^ 32'(a) ^ (32'(j + 1) << 24) ^ (we ? 32'h0080_0000 : 32'h0);
    endfunction

    // Slave models: acknowledge one cycle after request, data derived from the transfer
    logic [NUM_SLV-1:0] ack_r = '0;
    logic [NUM_SLV-1:0] spur  = '0;
    logic [31:0]        rd_r [NUM_SLV];
    always @(posedge clk) begin
        for (int j = 0; j < int'(NUM_SLV); j++) begin
            ack_r[j] <= rst ? 1'b0 : (s_req[j] & ~ack_r[j]);
            rd_r[j]  <= resp_word(j, s_we[j], s_addr[j*ADDR_W +: ADDR_W], s_wdata[j*DATA_W +: DATA_W]);
        end
    end
    assign s_ack = ack_r | spur;
    always_comb begin
        for (int j = 0; j < int'(NUM_SLV); j++) s_rdata[j*DATA_W +: DATA_W] = rd_r[j];
    end

    // Scoreboard
    typedef struct {
        bit          is_err;
        logic [31:0] rdata;
        int          due;
        string       tag;
    } exp_t;
    exp_t sbq [NUM_MST][$];

    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            for (int m = 0; m < int'(NUM_MST); m++) begin
                if (m_ack[m] || m_err[m]) begin
                    if (sbq[m].size() == 0) begin
                        chk(0, "R9", $sformatf("unexpected response at master %0d", m + 1), 1, 0);
                    end else begin
                        e = sbq[m].pop_front();
                        chk(m_err[m] == e.is_err, e.tag, $sformatf("m%0d response kind", m + 1), m_err[m], e.is_err);
                        chk(cyc == e.due, e.tag, $sformatf("m%0d response cycle", m + 1), cyc, e.due);
                        if (!e.is_err)
                            chk(m_rdata[m*DATA_W +: DATA_W] == e.rdata, e.tag,
                                $sformatf("m%0d read data", m + 1), m_rdata[m*DATA_W +: DATA_W], e.rdata);
                    end
                end
            end
        end
    end

    // Driver: master m (0-based) to slave sl (0-based); lat = expected response delay
    task automatic xfer(input int m, input int sl, input bit we, input logic [15:0] a,
                        input logic [31:0] d, input bit deny, input int lat, input string tag);
        exp_t e;
        e.is_err = deny;
        e.rdata  = resp_word(sl, we, a, d);
        e.due    = cyc + lat;
        e.tag    = tag;
        sbq[m].push_back(e);
        m_sel[m*SEL_W +: SEL_W]    = SEL_W'(sl);
        m_we[m]                    = we;
        m_addr[m*ADDR_W +: ADDR_W] = a;
        m_wdata[m*DATA_W +: DATA_W] = d;
        m_req[m]                   = 1'b1;
        do @(negedge clk); while (!(m_ack[m] || m_err[m]));
        if (deny)
            chk(!(s_req[sl] && s_addr[sl*ADDR_W +: ADDR_W] == a && s_wdata[sl*DATA_W +: DATA_W] == d),
                "R4", "denied transfer seen on slave port", s_req[sl], 0);
        m_req[m] = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(m_ack == '0, "R8", "m_ack in reset", m_ack, 0);
        chk(m_err == '0, "R8", "m_err in reset", m_err, 0);
        chk(s_req == '0, "R8", "s_req in reset", s_req, 0);
        rst = 1'b0;
        idle(2);
        // R7: idle ports quiet
        chk(s_req == '0 && s_addr == '0 && s_wdata == '0 && s_we == '0, "R7", "idle slave ports", s_req, 0);

        // R1/R3: single permitted transfers
        xfer(0, 0, 1, 16'h1001, 32'hA000_0001, 0, 2, "R1"); idle(2);
        xfer(1, 1, 0, 16'h1002, 32'hA000_0002, 0, 2, "R1"); idle(2);
        xfer(2, 2, 1, 16'h1003, 32'hA000_0003, 0, 2, "R3"); idle(2);
        xfer(3, 3, 0, 16'h1004, 32'hA000_0004, 0, 2, "R3"); idle(2);
        xfer(4, 7, 1, 16'h1005, 32'hA000_0005, 0, 2, "R3"); idle(2);

        // R3/R4: denied selects
        xfer(0, 4, 1, 16'h2001, 32'hB000_0001, 1, 1, "R4"); idle(2);
        xfer(1, 0, 0, 16'h2002, 32'hB000_0002, 1, 1, "R3"); idle(2);
        xfer(2, 5, 1, 16'h2003, 32'hB000_0003, 1, 1, "R3"); idle(2);
        xfer(3, 0, 0, 16'h2004, 32'hB000_0004, 1, 1, "R3"); idle(2);
        xfer(3, 1, 1, 16'h2005, 32'hB000_0005, 1, 1, "R3"); idle(2);
        xfer(4, 2, 0, 16'h2006, 32'hB000_0006, 1, 1, "R3"); idle(2);
        xfer(4, 5, 1, 16'h2007, 32'hB000_0007, 1, 1, "R4"); idle(2);

        // R2: five disjoint connections at once, two patterns
        fork
            xfer(0, 0, 1, 16'h3001, 32'hC000_0001, 0, 2, "R2");
            xfer(1, 1, 0, 16'h3002, 32'hC000_0002, 0, 2, "R2");
            xfer(2, 2, 1, 16'h3003, 32'hC000_0003, 0, 2, "R2");
            xfer(3, 3, 0, 16'h3004, 32'hC000_0004, 0, 2, "R2");
            xfer(4, 4, 1, 16'h3005, 32'hC000_0005, 0, 2, "R2");
        join
        idle(2);
        fork
            xfer(0, 5, 0, 16'h3101, 32'hC100_0001, 0, 2, "R2");
            xfer(1, 6, 1, 16'h3102, 32'hC100_0002, 0, 2, "R2");
            xfer(2, 7, 0, 16'h3103, 32'hC100_0003, 0, 2, "R2");
            xfer(3, 4, 1, 16'h3104, 32'hC100_0004, 0, 2, "R2");
            xfer(4, 3, 0, 16'h3105, 32'hC100_0005, 0, 2, "R2");
        join
        idle(2);

        // R4 with R1: denied and permitted master on slave 5 in the same cycle
        fork
            xfer(0, 4, 1, 16'h4001, 32'hD000_0001, 1, 1, "R4");
            xfer(3, 4, 1, 16'h4002, 32'hD000_0002, 0, 2, "R1");
        join
        idle(2);

        // R5: three-way contention on slave 3, pointer at master 4 -> order 1,2,3
        fork
            xfer(0, 2, 0, 16'h5001, 32'hE000_0001, 0, 2, "R5");
            xfer(1, 2, 1, 16'h5002, 32'hE000_0002, 0, 5, "R5");
            xfer(2, 2, 0, 16'h5003, 32'hE000_0003, 0, 8, "R5");
        join
        idle(2);

        // R6: slave 2 pointer at master 3 after last win by master 2 -> order 3,1,2
        fork
            xfer(0, 1, 1, 16'h6001, 32'hF000_0001, 0, 5, "R6");
            xfer(1, 1, 0, 16'h6002, 32'hF000_0002, 0, 8, "R6");
            xfer(2, 1, 1, 16'h6003, 32'hF000_0003, 0, 2, "R6");
        join
        idle(2);

        // R5: slave 7 pointer at master 3 -> master 5 before master 2
        fork
            xfer(1, 6, 0, 16'h6101, 32'hF100_0001, 0, 5, "R5");
            xfer(4, 6, 1, 16'h6102, 32'hF100_0002, 0, 2, "R5");
        join
        idle(2);

        // R9: acknowledge on an idle slave port reaches nobody
        spur[5] = 1'b1;
        #1;
        chk(m_ack == '0, "R9", "ack from unowned slave", m_ack, 0);
        @(negedge clk);
        chk(m_ack == '0 && s_req == '0, "R9", "after stray ack", {m_ack, s_req}, 0);
        spur[5] = 1'b0;
        idle(2);

        // R8: reset returns pointers to master 1 (slave 2 would otherwise pick master 3)
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        fork
            xfer(0, 1, 0, 16'h7001, 32'h9000_0001, 0, 2, "R8");
            xfer(2, 1, 1, 16'h7002, 32'h9000_0002, 0, 5, "R8");
        join
        idle(3);

        for (int m = 0; m < int'(NUM_MST); m++)
            chk(sbq[m].size() == 0, "R1", $sformatf("m%0d responses outstanding", m + 1), sbq[m].size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule